// File: doc/BRIEF.md
# Zero-Stuffing Upsampler

This block raises the sample count of a 12-bit audio stream by a factor of six. It places each incoming sample on its output and follows it with five zero-valued words. The resulting stream is ready for an interpolation filter, which then fills in the zeros. Filtering, gain correction and width changes belong to later stages.

On the upstream side the block is a slave. The producer presents a sample with a valid strobe. The block shows that it can take a sample with a ready line, and confirms each capture with a one-cycle acknowledge. On the downstream side the block is a master. It raises valid with the data only after the consumer has signalled ready. It then holds the word until the consumer acknowledges it, so backpressure stalls the whole insertion sequence at any point.

Reset is synchronous and active high. A synchronous active-high enable freezes every register while it is low.

Top module: `zstuff_upsampler`

## Requirements
- R1: Each accepted input sample produces exactly six downstream transfers. The first transfer carries the sample unchanged. A transfer is an enabled clock edge at which out_valid and dn_ack are both high.
- R2: in_ready is high only when en is high and no sample is pending. A sample is accepted at an edge where in_valid and in_ready are both high. in_ready then stays low until the sixth output of that sample has been transferred.
- R3: in_ack is high for exactly one cycle, in the cycle after an acceptance, and is never high otherwise.
- R4: The second through sixth outputs of every sample are the all-zero 12-bit word. out_data is also zero whenever out_valid is low.
- R5: out_valid rises only after an enabled edge at which dn_ready was high. It then stays high with stable out_data until a transfer. After each transfer it is low for at least one cycle.
- R6: While en is low, no sample is accepted and all state holds: out_valid, out_data and in_ack keep their values.
- R7: A synchronous reset clears out_valid and in_ack, discards any sequence in progress and returns the block to the idle state, where in_ready is high when en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous active-high enable |
| in_valid | input | 1 | Producer has a sample on in_data |
| in_data | input | 12 | Incoming sample, two's complement |
| in_ready | output | 1 | Block can accept a sample |
| in_ack | output | 1 | One-cycle confirmation of a captured sample |
| out_valid | output | 1 | out_data holds a word offered downstream |
| out_data | output | 12 | Outgoing word: the sample or zero |
| dn_ready | input | 1 | Consumer is able to take a word |
| dn_ack | input | 1 | Consumer has taken the offered word |

## Verification
Directed samples come first: all-zero, all-one, the most negative and the most positive values. They are sent with the consumer always ready and always acknowledging. This pattern shows whether the real sample passes through unaltered and can be told apart from the inserted zeros. Random streams follow, with random enable, random producer valid and random consumer ready and acknowledge. These streams stall the insertion at every phase and reveal any lost, duplicated or reordered word, as well as any early release of in_ready. A reset issued in the middle of a sequence shows whether the pending zeros are discarded and the block returns to idle cleanly.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_RATIO    = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARM   = 2'd1,
        SEQ_OFFER = 2'd2
    } seq_state_e;

    function automatic int phase_bits(input int ratio);
        return (ratio > 2) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/zs_capture.sv
module zs_capture #(
    parameter int SAMPLE_W = zs_pkg::DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                idle,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                accept,
    output logic                in_ready,
    output logic                in_ack,
    output logic [SAMPLE_W-1:0] held
);
    assign in_ready = en & idle;
    assign accept   = in_ready & in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_ack <= 1'b0;
            held   <= '0;
        end else if (en) begin
            in_ack <= accept;
            if (accept) begin
                held <= in_data;
            end
        end
    end
endmodule

// File: rtl/zs_sequencer.sv
module zs_sequencer #(
    parameter int RATIO = zs_pkg::DEF_RATIO,
    localparam int PW   = zs_pkg::phase_bits(RATIO)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic          dn_ready,
    input  logic          dn_ack,
    output logic          idle,
    output logic          out_valid,
    output logic [PW-1:0] phase
);
    import zs_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    seq_state_e state;

    assign idle      = (state == SEQ_IDLE);
    assign out_valid = (state == SEQ_OFFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            phase <= '0;
        end else if (en) begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_ARM;
                        phase <= '0;
                    end
                end
                SEQ_ARM: begin
                    if (dn_ready) begin
                        state <= SEQ_OFFER;
                    end
                end
                SEQ_OFFER: begin
                    if (dn_ack) begin
                        if (phase == LAST) begin
                            state <= SEQ_IDLE;
                            phase <= '0;
                        end else begin
                            state <= SEQ_ARM;
                            phase <= phase + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zs_word_sel.sv
module zs_word_sel #(
    parameter int SAMPLE_W = zs_pkg::DEF_SAMPLE_W,
    parameter int PW       = 3
) (
    input  logic                out_valid,
    input  logic [PW-1:0]       phase,
    input  logic [SAMPLE_W-1:0] held,
    output logic [SAMPLE_W-1:0] out_data
);
    always_comb begin
        out_data = '0;
        if (out_valid && phase == '0) begin
            out_data = held;
        end
    end
endmodule

// File: rtl/zstuff_upsampler.sv
module zstuff_upsampler #(
    parameter int SAMPLE_W = zs_pkg::DEF_SAMPLE_W,
    parameter int RATIO    = zs_pkg::DEF_RATIO
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                in_ready,
    output logic                in_ack,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    input  logic                dn_ready,
    input  logic                dn_ack
);
    localparam int PW = zs_pkg::phase_bits(RATIO);

    logic                idle;
    logic                accept;
    logic [PW-1:0]       phase;
    logic [SAMPLE_W-1:0] held;

    zs_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
        .clk(clk), .rst(rst), .en(en), .idle(idle),
        .in_valid(in_valid), .in_data(in_data),
        .accept(accept), .in_ready(in_ready), .in_ack(in_ack), .held(held)
    );

    zs_sequencer #(.RATIO(RATIO)) u_seq (
        .clk(clk), .rst(rst), .en(en), .start(accept),
        .dn_ready(dn_ready), .dn_ack(dn_ack),
        .idle(idle), .out_valid(out_valid), .phase(phase)
    );

    zs_word_sel #(.SAMPLE_W(SAMPLE_W), .PW(PW)) u_sel (
        .out_valid(out_valid), .phase(phase), .held(held), .out_data(out_data)
    );
endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
    parameter int SAMPLE_W = 12,
    parameter int PW       = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                in_valid,
    input logic                in_ready,
    input logic                in_ack,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_data,
    input logic                dn_ready,
    input logic                dn_ack,
    input logic [PW-1:0]       phase
);
    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(dn_ack && en) |=> out_valid && $stable(out_data));

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(dn_ready && en));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ack && en |=> !in_ack);

    // R3
    ack_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ack) |-> $past(in_valid && in_ready));

    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && phase != '0 |-> out_data == '0);

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_valid) && $stable(in_ack) && $stable(out_data));
endmodule

bind zstuff_upsampler zs_checker #(.SAMPLE_W(SAMPLE_W), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
    .dn_ready(dn_ready), .dn_ack(dn_ack), .phase(phase)
);

// File: tb/zstuff_upsampler_bench.sv
module zstuff_upsampler_bench;
    localparam int W = 12;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         dn_ready = 1'b0;
    logic         dn_ack = 1'b0;
    logic         in_ready, in_ack, out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit           busy_m = 0;
    bit           ack_m = 0;
    int           phase_m = 0;
    logic [W-1:0] smp_m = '0;
    // previous-cycle observations
    bit           p_en = 0, p_ov = 0, p_ack_in = 0, p_dack = 0, p_drdy = 0;
    logic [W-1:0] p_data = '0;

    always #2 clk = ~clk;

    zstuff_upsampler u_zstuff_upsampler (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .in_ack(in_ack), .out_valid(out_valid),
        .out_data(out_data), .dn_ready(dn_ready), .dn_ack(dn_ack)
    );

    function automatic logic [W-1:0] expect_word(input logic [W-1:0] s, input int ph);
        return (ph == 0) ? s : '0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        busy_m = 0; ack_m = 0; phase_m = 0;
        p_en = 0; p_ov = 0; p_ack_in = 0; p_dack = 0; p_drdy = 0; p_data = '0;
        en = 1'b1;
        #0;
        // R7 reset state
        chk(out_valid == 1'b0, "R7 out_valid", W'(out_valid), '0);
        chk(in_ack == 1'b0, "R7 in_ack", W'(in_ack), '0);
        chk(in_ready == 1'b1, "R7 in_ready", W'(in_ready), W'(1));
        chk(out_data == '0, "R7 out_data", out_data, '0);
    endtask

    // one cycle: checks at negedge, then drive, then advance model
    task automatic step(input bit e, input bit iv, input logic [W-1:0] d,
                        input bit rdy, input bit ak);
        bit xfer, acc;
        // R6
        if (!p_en) begin
            chk(out_valid == p_ov, "R6 out_valid frozen", W'(out_valid), W'(p_ov));
            chk(out_data == p_data, "R6 out_data frozen", out_data, p_data);
            chk(in_ack == p_ack_in, "R6 in_ack frozen", W'(in_ack), W'(p_ack_in));
        end
        // R3
        chk(in_ack == ack_m, "R3 in_ack", W'(in_ack), W'(ack_m));
        // R5
        if (p_ov && !(p_dack && p_en)) begin
            chk(out_valid && out_data == p_data, "R5 hold", out_data, p_data);
        end
        if (p_ov && p_dack && p_en) begin
            chk(!out_valid, "R5 drop after transfer", W'(out_valid), '0);
        end
        if (!p_ov && out_valid) begin
            chk(p_drdy && p_en, "R5 rise after ready", W'(p_drdy), W'(1));
        end
        // R4
        if (!out_valid) begin
            chk(out_data == '0, "R4 idle data zero", out_data, '0);
        end
        en = e; in_valid = iv; in_data = d; dn_ready = rdy; dn_ack = ak;
        #0;
        // R2
        chk(in_ready == (e && !busy_m), "R2 in_ready", W'(in_ready), W'(e && !busy_m));
        xfer = out_valid && ak && e;
        acc  = e && !busy_m && iv;
        if (xfer) begin
            // R1 / R4
            chk(busy_m && out_data == expect_word(smp_m, phase_m),
                (phase_m == 0) ? "R1 sample word" : "R4 zero word",
                out_data, expect_word(smp_m, phase_m));
            if (phase_m == N - 1) begin
                busy_m = 0; phase_m = 0;
            end else begin
                phase_m++;
            end
        end
        if (e) ack_m = acc;
        if (acc) begin
            busy_m = 1; phase_m = 0; smp_m = d;
        end
        p_en = e; p_ov = out_valid; p_data = out_data; p_ack_in = in_ack;
        p_dack = ak; p_drdy = rdy;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] dir [4];
        void'($urandom(32'd1234));
        dir[0] = 12'h000; dir[1] = 12'hFFF; dir[2] = 12'h800; dir[3] = 12'h7FF;
        repeat (3) @(negedge clk);
        do_reset();
        // directed: full-rate, extreme sample values (R1, R4)
        for (int k = 0; k < 4; k++) begin
            step(1, 1, dir[k], 1, 1);
            while (busy_m) step(1, 0, 12'h5A5, 1, 1);
        end
        // directed: stall with ready but no ack for several cycles (R5)
        step(1, 1, 12'h123, 1, 0);
        for (int k = 0; k < 8; k++) step(1, 1, 12'h321, 1, 0);
        // directed: enable low mid-offer (R6)
        for (int k = 0; k < 5; k++) step(0, 1, 12'h456, 1, 1);
        while (busy_m) step(1, 1, 12'h654, 1, 1);
        // directed: reset in the middle of a sequence (R7)
        step(1, 1, 12'hABC, 1, 1);
        step(1, 0, 12'h000, 1, 1);
        step(1, 0, 12'h000, 1, 1);
        do_reset();
        for (int k = 0; k < 12; k++) step(1, 1, 12'h0F0, 1, 1);
        // constrained random
        for (int k = 0; k < 6000; k++) begin
            step(($urandom % 10) != 0, ($urandom % 3) != 0, W'($urandom),
                 ($urandom % 4) != 0, ($urandom % 3) != 0);
        end
        finish_run();
    end
endmodule